// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets an on-chip requester read and write an external asynchronous static RAM of 32K words by 8 bits. The requester uses a valid/ready handshake. A request carries a 15-bit address, a write flag and 8-bit write data. Each read returns its data together with a one-cycle valid strobe.

On the memory side the block drives three active-low strobes (chip enable, write enable and output enable), the address bus and a tri-stated 8-bit data bus. Every memory timing limit is given in picoseconds and converted into whole clock cycles at elaboration. Each count is the ceiling of the limit divided by the clock period, and is never less than one cycle.

The block has four jobs:
- It waits out the memory's power-up interval before it accepts any request.
- It holds address and data steady for the whole access.
- It puts a quiet gap between a read and any later drive of the data bus.
- It keeps the memory deselected whenever no access is running, so the part falls into standby.

Top module: `xsram_ctrl`

## Requirements
- R1: After reset, all three strobes are high and `req_ready` stays low for at least PWR_CYC = ceil(100 us / period) cycles. With the 4 ns default this is 25000 cycles. `req_ready` then rises within three further cycles.
- R2: An accepted read holds chip enable and output enable low and write enable high for exactly RD_CYC = max(ceil(10 ns/period), ceil(5 ns/period)) cycles, which is 3 cycles at the default. `rsp_valid` is seen in the cycle right after the strobes rise, which is RD_CYC+1 cycles after the accepting edge.
- R3: `rsp_rdata` equals the byte most recently written to that address.
- R4: Write enable low implies chip enable low and output enable high. An accepted write holds chip enable and write enable low together for WR_CYC = max(ceil(10 ns/period), ceil(7 ns/period), ceil(6 ns/period)) cycles, which is 3 at the default.
- R5: During a write, the controller drives the request's data onto `mem_dq` unchanged from the first cycle of the write pulse. It keeps driving it for one cycle after the strobes rise, and the byte stored is that data.
- R6: Once output enable rises at the end of a read, at least REL_CYC = ceil(5 ns/period) cycles pass before write enable falls. This is 2 cycles at the default.
- R7: While `req_ready` is high, chip enable is high, so the memory is in standby.
- R8: The address is captured at acceptance. `mem_addr` stays constant while chip enable is low, whatever `req_addr` does during the access, and `req_ready` is low while an access runs.
- R9: `rsp_valid` lasts exactly one cycle per read and never pulses for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle strobe, read data valid |
| rsp_rdata | output | 8 | Read data |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 15 | Memory address bus |
| mem_dq | inout | 8 | Memory data bus, tri-stated |

## Verification
The bench uses four kinds of stimulus, and each one tells apart a different fault:
- Directed writes and reads at the lowest and highest addresses show whether the address and data paths are wired correctly.
- A write followed at once by a read of the same word shows whether the write commits before the next access.
- A read followed at once by a write exercises the turnaround gap and would catch a write pulse issued too early.
- Random mixes over a small pool of addresses, with `req_addr` and `req_wdata` scrambled during each access, separate true capture at acceptance from a design that passes the request lines through.

A behavioural memory on the pins measures the length of each strobe window and the stability of address and data. It stores only what it actually sees on the bus.

// File: rtl/xsram_pkg.sv
// Shared types and the time-to-cycles helper for the SRAM access controller.
package xsram_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        S_PWR   = 3'd0,
        S_IDLE  = 3'd1,
        S_RD    = 3'd2,
        S_TURN  = 3'd3,
        S_WR    = 3'd4,
        S_WHOLD = 3'd5
    } seq_st_t;

    // Whole cycles needed to cover t_ps at period clk_ps, never below one
    function automatic int cyc_of(input int t_ps, input int clk_ps);
        int n;
        n = (t_ps + clk_ps - 1) / clk_ps;
        return (n < 1) ? 1 : n;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/xsram_pwrup.sv
// Power-up wait: counts PWR_CYC cycles after reset, then raises done for good.
// Assumes the supply is stable once reset is released.
module xsram_pwrup #(
    parameter int PWR_CYC = 25000,
    localparam int PW_W   = $clog2(PWR_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    logic [PW_W-1:0] cnt;

    // Count up to the limit, then latch done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            if (cnt == PW_W'(PWR_CYC - 1)) begin
                done <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/xsram_timer.sv
// Loadable down-counter that times each phase; zero flags the last cycle.
module xsram_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    // Load on request, otherwise count down to zero and stay there
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/xsram_seq.sv
// Access sequencer. It accepts one request at a time, registers the address and
// data, and drives the memory strobes through the read, turnaround, write and
// hold phases. Every strobe comes from a flop, so no glitches reach the pins.
// It assumes the phase timer was loaded with (phase length - 1).
module xsram_seq
    import xsram_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int DATA_W  = 8,
    parameter int RD_CYC  = 3,
    parameter int WR_CYC  = 3,
    parameter int REL_CYC = 2,
    parameter int CNT_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_done,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              ce_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [ADDR_W-1:0] addr,
    output logic              dq_oe,
    output logic [DATA_W-1:0] dq_out,
    input  logic [DATA_W-1:0] dq_in,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    input  logic              tmr_zero
);
    seq_st_t st;
    logic    accept;

    assign req_ready = (st == S_IDLE);
    assign accept    = req_ready && req_valid;

    // Choose when and with what the phase timer is loaded
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (accept) begin
            tmr_load = 1'b1;
            tmr_val  = req_we ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
        end else if (st == S_RD && tmr_zero) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(REL_CYC - 1);
        end
    end

    // Phase state machine with registered strobes and bus driver
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_PWR;
            ce_n      <= 1'b1;
            we_n      <= 1'b1;
            oe_n      <= 1'b1;
            addr      <= '0;
            dq_oe     <= 1'b0;
            dq_out    <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (st)
                S_PWR: begin
                    if (pwr_done) st <= S_IDLE;
                end
                S_IDLE: begin
                    if (req_valid) begin
                        addr <= req_addr;
                        ce_n <= 1'b0;
                        if (req_we) begin
                            we_n   <= 1'b0;
                            dq_oe  <= 1'b1;
                            dq_out <= req_wdata;
                            st     <= S_WR;
                        end else begin
                            oe_n <= 1'b0;
                            st   <= S_RD;
                        end
                    end
                end
                S_RD: begin
                    if (tmr_zero) begin
                        rsp_rdata <= dq_in;
                        rsp_valid <= 1'b1;
                        ce_n      <= 1'b1;
                        oe_n      <= 1'b1;
                        st        <= S_TURN;
                    end
                end
                S_TURN: begin
                    if (tmr_zero) st <= S_IDLE;
                end
                S_WR: begin
                    if (tmr_zero) begin
                        ce_n <= 1'b1;
                        we_n <= 1'b1;
                        st   <= S_WHOLD;
                    end
                end
                S_WHOLD: begin
                    dq_oe <= 1'b0;
                    st    <= S_IDLE;
                end
                default: st <= S_PWR;
            endcase
        end
    end
endmodule

// File: rtl/xsram_ctrl.sv
// Top of the asynchronous SRAM access controller. It converts the timing
// limits (in ps) to cycle counts and joins the power-up wait, the phase timer,
// the sequencer and the tri-state data pad. It assumes one clock domain and
// that the memory shares no bus with any other driver.
module xsram_ctrl
    import xsram_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int CLK_PS    = 4000,
    parameter int T_CYC_PS  = 10000,
    parameter int T_ACC_PS  = 10000,
    parameter int T_OE_PS   = 5000,
    parameter int T_WP_PS   = 7000,
    parameter int T_AS_PS   = 7000,
    parameter int T_DS_PS   = 6000,
    parameter int T_REL_PS  = 5000,
    parameter int T_PWR_PS  = 100_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_dq
);
    localparam int RD_CYC  = max2(max2(cyc_of(T_CYC_PS, CLK_PS), cyc_of(T_ACC_PS, CLK_PS)),
                                  cyc_of(T_OE_PS, CLK_PS));
    localparam int WR_CYC  = max2(max2(cyc_of(T_CYC_PS, CLK_PS), cyc_of(T_WP_PS, CLK_PS)),
                                  max2(cyc_of(T_AS_PS, CLK_PS), cyc_of(T_DS_PS, CLK_PS)));
    localparam int REL_CYC = cyc_of(T_REL_PS, CLK_PS);
    localparam int PWR_CYC = cyc_of(T_PWR_PS, CLK_PS);
    localparam int PH_MAX  = max2(max2(RD_CYC, WR_CYC), REL_CYC);
    localparam int CNT_W   = (PH_MAX < 2) ? 1 : $clog2(PH_MAX);

    logic              pwr_done;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic              dq_oe;
    logic [DATA_W-1:0] dq_out;

    xsram_pwrup #(.PWR_CYC(PWR_CYC)) u_pwrup (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (pwr_done)
    );

    xsram_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    xsram_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .RD_CYC (RD_CYC),
        .WR_CYC (WR_CYC),
        .REL_CYC(REL_CYC),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_done (pwr_done),
        .req_valid(req_valid),
        .req_we   (req_we),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .req_ready(req_ready),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata),
        .ce_n     (mem_ce_n),
        .we_n     (mem_we_n),
        .oe_n     (mem_oe_n),
        .addr     (mem_addr),
        .dq_oe    (dq_oe),
        .dq_out   (dq_out),
        .dq_in    (mem_dq),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .tmr_zero (tmr_zero)
    );

    // Data pad: drive only while the sequencer owns the bus
    assign mem_dq = dq_oe ? dq_out : {DATA_W{1'bz}};
endmodule

// File: rtl/xsram_ctrl_chk.sv
// Protocol checker bound to the controller top. It watches only the ports and
// keeps its own counters for the power-up and turnaround windows.
module xsram_ctrl_chk #(
    parameter int ADDR_W  = 15,
    parameter int PWR_CYC = 25000,
    parameter int REL_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [ADDR_W-1:0] mem_addr
);
    int pw_cnt;
    int quiet_cnt;

    // Cycles since reset, saturating at the power-up limit
    always_ff @(posedge clk) begin
        if (!rst_n)                pw_cnt <= 0;
        else if (pw_cnt < PWR_CYC) pw_cnt <= pw_cnt + 1;
    end

    // Cycles since output enable was last low, saturating at the gap length
    always_ff @(posedge clk) begin
        if (!rst_n)                    quiet_cnt <= REL_CYC;
        else if (!mem_oe_n)            quiet_cnt <= 0;
        else if (quiet_cnt < REL_CYC)  quiet_cnt <= quiet_cnt + 1;
    end

    // R1
    pwrup_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_cnt < PWR_CYC) |-> (!req_ready && mem_ce_n));

    // R2
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!mem_oe_n));

    // R4
    write_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n));

    // R6
    turnaround_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (quiet_cnt >= REL_CYC));

    // R7
    idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_ce_n);

    // R8
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    // R8
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);

    // R9
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

bind xsram_ctrl xsram_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .PWR_CYC(PWR_CYC),
    .REL_CYC(REL_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .mem_ce_n (mem_ce_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .mem_addr (mem_addr)
);

// File: tb/xsram_ctrl_test.sv
// Bench: a behavioural memory on the pins plus random and directed requests.
module xsram_ctrl_test;
    localparam int CLK_PS = 4000;

    function automatic int cyc(input int t_ps);
        int n;
        n = (t_ps + CLK_PS - 1) / CLK_PS;
        return (n < 1) ? 1 : n;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_RD  = mx(mx(cyc(10000), cyc(10000)), cyc(5000));
    localparam int E_WR  = mx(mx(cyc(10000), cyc(7000)), mx(cyc(7000), cyc(6000)));
    localparam int E_REL = cyc(5000);
    localparam int E_PWR = cyc(100_000_000);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic        mem_ce_n, mem_we_n, mem_oe_n;
    logic [14:0] mem_addr;
    wire  [7:0]  mem_dq;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit mon_en = 1'b0;
    bit done_flag = 1'b0;

    always #2ns clk = ~clk;

    xsram_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_addr(mem_addr), .mem_dq(mem_dq)
    );

    // ---------------- behavioural memory ----------------
    logic [7:0] pin_mem [int];
    logic [7:0] ref_mem [int];
    logic [7:0] model_q;
    bit         model_upd = 1'b0;
    logic       model_drv;

    assign model_drv = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign mem_dq    = model_drv ? model_q : 8'bz;

    always @(mem_addr or model_upd) begin
        model_q = pin_mem.exists(int'(mem_addr)) ? pin_mem[int'(mem_addr)] : 8'h00;
    end

    function automatic logic [7:0] ref_get(input logic [14:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- pin monitor ----------------
    int          rd_run = 0, last_rd_run = 0, wr_run = 0, quiet = 100;
    logic [14:0] rd_addr, wr_addr;
    logic [7:0]  wr_data;
    bit          rd_abad = 0, last_rd_abad = 0, wr_bad = 0;

    always @(negedge clk) begin
        if (mon_en) begin
            // R7 standby while idle
            if (req_ready && !mem_ce_n) chk(0, "R7 ce_n while ready", 0, 1);
            if (!mem_we_n && !mem_oe_n) chk(0, "R4 oe_n during write", 0, 1);
            if (model_drv) begin
                if (rd_run > 0 && mem_addr != rd_addr) rd_abad = 1;
                rd_run++;
                rd_addr = mem_addr;
                quiet = 0;
            end else begin
                if (rd_run > 0) begin
                    last_rd_run = rd_run;
                    last_rd_abad = rd_abad;
                end
                rd_run = 0;
                rd_abad = 0;
                if (quiet < 100) quiet++;
            end
            if (!mem_ce_n && !mem_we_n) begin
                if (wr_run == 0) begin
                    // R6 quiet bus before the write drive
                    chk(quiet >= E_REL, "R6 turnaround gap", quiet, E_REL);
                    wr_addr = mem_addr;
                    wr_data = mem_dq;
                    wr_bad = 0;
                end else if (mem_addr != wr_addr || mem_dq !== wr_data) begin
                    wr_bad = 1;
                end
                wr_run++;
            end else if (wr_run > 0) begin
                chk(wr_run == E_WR, "R4 write pulse length", wr_run, E_WR);
                // R5 data held after the pulse and stable throughout
                chk(!wr_bad && mem_dq === wr_data && mem_addr == wr_addr,
                    "R5 write data stable/held", int'(mem_dq), int'(wr_data));
                pin_mem[int'(wr_addr)] = mem_dq;
                model_upd = !model_upd;
                wr_run = 0;
            end
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done_flag) begin
            done_flag = 1;
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // ---------------- request tasks ----------------
    task automatic wait_ready();
        int n = 0;
        while (!req_ready && n < 100) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic issue(input bit we, input logic [14:0] a, input logic [7:0] d);
        wait_ready();
        req_valid = 1;
        req_we = we;
        req_addr = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        // R8 scramble the request lines during the access
        req_addr = 15'($urandom);
        req_wdata = 8'($urandom);
        req_we = 1'($urandom);
    endtask

    task automatic do_write(input logic [14:0] a, input logic [7:0] d);
        int seen = 0;
        issue(1, a, d);
        ref_mem[int'(a)] = d;
        for (int i = 0; i < E_WR + 2; i++) begin
            if (rsp_valid) seen++;
            if (i == 0) chk(!req_ready, "R8 ready low during write", int'(req_ready), 0);
            @(negedge clk);
        end
        chk(seen == 0, "R9 no rsp on write", seen, 0);
    endtask

    task automatic do_read(input logic [14:0] a);
        logic [7:0] e;
        int         lat = 1;
        e = ref_get(a);
        issue(0, a, 8'h00);
        while (!rsp_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == E_RD + 1, "R2 read latency", lat, E_RD + 1);
        chk(rsp_rdata == e, "R3 read data", int'(rsp_rdata), int'(e));
        @(negedge clk);
        chk(!rsp_valid, "R9 single pulse", int'(rsp_valid), 0);
        chk(last_rd_run == E_RD && !last_rd_abad, "R2/R8 read window", last_rd_run, E_RD);
    endtask

    function automatic logic [14:0] pick_addr();
        int r;
        r = int'($urandom % 20);
        if (r == 0) return 15'h0000;
        if (r == 1) return 15'h7FFF;
        return 15'((r * 2731 + 5) & 32'h7FFF);
    endfunction

    // ---------------- main sequence ----------------
    initial begin
        int dummy;
        int low_ok;
        int n;
        dummy = $urandom(32'd1234);
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(mem_ce_n && mem_we_n && mem_oe_n && !req_ready && !rsp_valid,
            "R1 reset state", {mem_ce_n, mem_we_n, mem_oe_n, req_ready}, 4'b1110);
        rst_n = 1;
        mon_en = 1;
        low_ok = 1;
        for (int i = 1; i <= E_PWR; i++) begin
            @(negedge clk);
            if (req_ready || !mem_ce_n) low_ok = 0;
        end
        chk(low_ok == 1, "R1 no access during power-up", low_ok, 1);
        n = 0;
        while (!req_ready && n < 4) begin
            @(negedge clk);
            n++;
        end
        chk(req_ready, "R1 ready after power-up", int'(req_ready), 1);
        // directed corners
        do_write(15'h0000, 8'h5A);
        do_write(15'h7FFF, 8'hA5);
        do_read(15'h0000);
        do_read(15'h7FFF);
        do_write(15'h1234, 8'hC3);
        do_read(15'h1234);          // write then read, same word
        do_write(15'h1234, 8'h3C);  // read then write: turnaround
        do_read(15'h1234);
        do_write(15'h0000, 8'hFF);
        do_write(15'h0000, 8'h00);  // back-to-back overwrite
        do_read(15'h0000);
        // random mix
        for (int k = 0; k < 400; k++) begin
            if ($urandom % 2) do_write(pick_addr(), 8'($urandom));
            else              do_read(pick_addr());
        end
        repeat (4) @(negedge clk);
        done_flag = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule